// File: doc/BRIEF.md
# Dual-Mode Quad-Channel Host Bus Front End

This block connects a host processor bus to four identical serial-channel register files. A strap input picks one of two bus styles. In the strobe style the host uses separate read and write strobes and one active-low select per channel, and each channel has its own active-high interrupt line. In the direction style a single active-low select enables the group, a read/write direction line sets the transfer type, and two extra address bits pick the channel. The four interrupt requests then merge into one active-low, open-drain line.

The block decodes the target channel and produces one read enable and one write enable per channel. It passes the 3-bit register index to the chosen channel and returns that channel's read data. It also sets the reset polarity from the strap, routes the interrupts, and selects the per-channel clock prescaler from a pin and an override bit. The channels are register stubs with eight 8-bit registers each. Register 1 bit 0 is the channel's interrupt request. Register 4 bit 7 is the prescaler override.

Top module: `qbus_front`

## Requirements
- R1: With `bus_sep` high, a read (`rd_n` low, `wr_n` high) with exactly one select low places register `addr` of that channel on `dout` with `dout_oe` high in the same cycle. A write (`wr_n` low, `rd_n` high) stores `din` into that register at the clock edge.
- R2: In the strobe style, `sel0_n` selects channel 0, `xa3` channel 1, `xa4` channel 2 and `sel3_n` channel 3, all active low.
- R3: With `bus_sep` low, `sel0_n` low enables an access. `wr_n` high is a read and `wr_n` low is a write. The channel index is {`xa4`,`xa3`}, with `xa4` as the MSB. `rd_n` and `sel3_n` have no effect.
- R4: If no channel is selected, no access takes place. This covers no select low, more than one select low, or both strobes low in the strobe style, and `sel0_n` high in the direction style. `dout_oe` stays low and no register changes.
- R5: The reset is synchronous. In the strobe style `rst_pin` is active high. In the direction style it is active low. Reset clears every register to zero.
- R6: In the strobe style, `irq_hi[i]` equals register 1 bit 0 of channel i, and `irq_od_dl` is low.
- R7: In the direction style, `irq_hi` is all zero. `irq_od_dl` (drive-low enable of the open-drain line) is high exactly when any channel's register 1 bit 0 is set.
- R8: `div4_sel[i]` is high (divide-by-4) when `clk_sel` is low or when channel i's register 4 bit 7 is set. Otherwise it is low (divide-by-1).
- R9: The override bit (register 4 bit 7) reads 0 after reset, so the pin alone decides the prescaler.
- R10: `dout_oe` is high only during a decoded read. When it is low, `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_pin | input | 1 | Reset pin, polarity set by bus style |
| bus_sep | input | 1 | Strap: 1 selects the strobe style, 0 the direction style |
| sel0_n | input | 1 | Channel 0 select (strobe style) or group select (direction style) |
| xa3 | input | 1 | Channel 1 select (strobe style) or channel index LSB |
| xa4 | input | 1 | Channel 2 select (strobe style) or channel index MSB |
| sel3_n | input | 1 | Channel 3 select, strobe style only |
| rd_n | input | 1 | Read strobe, strobe style only |
| wr_n | input | 1 | Write strobe, or read/write direction line |
| addr | input | 3 | Register index within the channel |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data to the host |
| dout_oe | output | 1 | Read data output enable |
| clk_sel | input | 1 | Prescaler pin: 1 divide-by-1, 0 divide-by-4 |
| irq_hi | output | 4 | Per-channel active-high interrupts (strobe style) |
| irq_od_dl | output | 1 | Drive-low enable for the shared open-drain interrupt |
| div4_sel | output | 4 | Per-channel divide-by-4 selection |

## Verification
The assertions assume the host changes the bus pins only away from the clock edge. They also assume the strap and the reset pin change together, so that a change of bus style never looks like a reset pulse in the new polarity. The stimulus drives every pin on the falling edge and switches `bus_sep` in the same step as `rst_pin` moves to the inactive level of the new style. Collision and idle patterns are applied on purpose, so the decode assertions see them. The sweeps cover every channel and register index in both styles, and also apply direction-style patterns with `rd_n` and `sel3_n` held at misleading levels.

// File: rtl/qbus_pkg.sv
package qbus_pkg;
  localparam int NCH = 4;
  localparam int CHW = $clog2(NCH);

  typedef struct packed {
    logic           hit;
    logic [CHW-1:0] ch;
  } chsel_t;

  typedef enum logic [1:0] {ACC_NONE = 2'd0, ACC_RD = 2'd1, ACC_WR = 2'd2} acc_e;

  // reset polarity follows the bus style
  function automatic logic f_rst_active(input logic sep, input logic pin);
    return sep ? pin : ~pin;
  endfunction

  // strobe style: exactly one active-low select picks a channel
  function automatic chsel_t f_sep_pick(input logic [NCH-1:0] sel_n);
    chsel_t r;
    int     cnt;
    r   = '0;
    cnt = 0;
    for (int i = 0; i < NCH; i++) begin
      if (!sel_n[i]) begin
        cnt++;
        r.ch = CHW'(i);
      end
    end
    r.hit = (cnt == 1);
    if (!r.hit) r.ch = '0;
    return r;
  endfunction

  // direction style: group select plus index bits
  function automatic chsel_t f_dir_pick(input logic grp_n, input logic [CHW-1:0] idx);
    chsel_t r;
    r.hit = ~grp_n;
    r.ch  = idx;
    return r;
  endfunction

  function automatic acc_e f_sep_kind(input logic rd_n, input logic wr_n);
    if (!rd_n && wr_n) return ACC_RD;
    if (!wr_n && rd_n) return ACC_WR;
    return ACC_NONE;
  endfunction

  function automatic acc_e f_dir_kind(input logic rw);
    return rw ? ACC_RD : ACC_WR;
  endfunction

  function automatic logic f_div4(input logic pin, input logic ovr);
    return ~pin | ovr;
  endfunction
endpackage

// File: rtl/qbus_decode.sv
module qbus_decode
  import qbus_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_sep,
  input  logic           sel0_n,
  input  logic           xa3,
  input  logic           xa4,
  input  logic           sel3_n,
  input  logic           rd_n,
  input  logic           wr_n,
  output logic [NCH-1:0] rd_en,
  output logic [NCH-1:0] wr_en,
  output logic [CHW-1:0] pick_ch
);
  chsel_t pick_sep, pick_dir, pick;
  acc_e   kind;
  logic   ev_access;

  always_comb begin
    pick_sep = f_sep_pick({sel3_n, xa4, xa3, sel0_n});
    pick_dir = f_dir_pick(sel0_n, {xa4, xa3});
    pick     = bus_sep ? pick_sep : pick_dir;
    kind     = bus_sep ? f_sep_kind(rd_n, wr_n) : f_dir_kind(wr_n);
  end

  assign pick_ch   = pick.ch;
  assign ev_access = pick.hit && (kind != ACC_NONE);

  for (genvar i = 0; i < NCH; i++) begin : g_en
    assign rd_en[i] = ev_access && (kind == ACC_RD) && (pick.ch == CHW'(i));
    assign wr_en[i] = ev_access && (kind == ACC_WR) && (pick.ch == CHW'(i));
  end

  // R4: at most one channel enabled
  a_r4_one_channel: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_en | wr_en));
  // R4: idle strobe-style bus yields no enable
  a_r4_idle_sep: assert property (@(posedge clk) disable iff (rst)
    (bus_sep && sel0_n && xa3 && xa4 && sel3_n) |-> ((rd_en | wr_en) == '0));
  // R4: group select high in direction style yields no enable
  a_r4_idle_dir: assert property (@(posedge clk) disable iff (rst)
    (!bus_sep && sel0_n) |-> ((rd_en | wr_en) == '0));
  // R2: lone xa3 write targets channel 1
  a_r2_ch1_map: assert property (@(posedge clk) disable iff (rst)
    (bus_sep && sel0_n && !xa3 && xa4 && sel3_n && !wr_n && rd_n) |-> (wr_en == 4'b0010));
  // R3: direction line alone sets the transfer type
  a_r3_dir_read: assert property (@(posedge clk) disable iff (rst)
    (!bus_sep && !sel0_n && wr_n) |-> (wr_en == '0 && $onehot(rd_en)));
endmodule

// File: rtl/qbus_chan_regs.sv
module qbus_chan_regs #(
  parameter int DW      = 8,
  parameter int AW      = 3,
  parameter int IRQ_IDX = 1,
  parameter int MCR_IDX = 4,
  parameter int OVR_BIT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_req,
  output logic          mcr_ovr
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata   = mem[addr];
  assign irq_req = mem[IRQ_IDX][0];
  assign mcr_ovr = mem[MCR_IDX][OVR_BIT];

  // R1: a write lands in the addressed register
  a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(addr)] == $past(wdata)));
  // R9: override bit is clear after reset
  a_r9_ovr_reset: assert property (@(posedge clk)
    rst |=> !mcr_ovr);
  // R5: reset clears the interrupt request too
  a_r5_irq_reset: assert property (@(posedge clk)
    rst |=> !irq_req);
endmodule

// File: rtl/qbus_irq_route.sv
module qbus_irq_route
  import qbus_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_sep,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] irq_hi,
  output logic           irq_od_dl
);
  logic any_req;

  assign any_req   = |req;
  assign irq_hi    = bus_sep ? req : '0;
  assign irq_od_dl = ~bus_sep & any_req;

  // R6: open-drain line is released in strobe style
  a_r6_od_quiet: assert property (@(posedge clk) disable iff (rst)
    bus_sep |-> !irq_od_dl);
  // R7: separate lines are quiet in direction style
  a_r7_hi_quiet: assert property (@(posedge clk) disable iff (rst)
    !bus_sep |-> (irq_hi == '0));
  // R7: any request pulls the shared line
  a_r7_od_pull: assert property (@(posedge clk) disable iff (rst)
    (!bus_sep && req != '0) |-> irq_od_dl);
endmodule

// File: rtl/qbus_front.sv
module qbus_front
  import qbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic           clk,
  input  logic           rst_pin,
  input  logic           bus_sep,
  input  logic           sel0_n,
  input  logic           xa3,
  input  logic           xa4,
  input  logic           sel3_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  din,
  output logic [DW-1:0]  dout,
  output logic           dout_oe,
  input  logic           clk_sel,
  output logic [NCH-1:0] irq_hi,
  output logic           irq_od_dl,
  output logic [NCH-1:0] div4_sel
);
  logic           rst;
  logic [NCH-1:0] rd_en, wr_en, req, ovr;
  logic [CHW-1:0] pick_ch;
  logic [DW-1:0]  rdata [NCH];

  assign rst = f_rst_active(bus_sep, rst_pin);

  qbus_decode u_dec (
    .clk(clk), .rst(rst), .bus_sep(bus_sep),
    .sel0_n(sel0_n), .xa3(xa3), .xa4(xa4), .sel3_n(sel3_n),
    .rd_n(rd_n), .wr_n(wr_n),
    .rd_en(rd_en), .wr_en(wr_en), .pick_ch(pick_ch)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    qbus_chan_regs #(.DW(DW), .AW(AW)) u_regs (
      .clk(clk), .rst(rst), .we(wr_en[i]), .addr(addr), .wdata(din),
      .rdata(rdata[i]), .irq_req(req[i]), .mcr_ovr(ovr[i])
    );
    assign div4_sel[i] = f_div4(clk_sel, ovr[i]);
  end

  qbus_irq_route u_irq (
    .clk(clk), .rst(rst), .bus_sep(bus_sep), .req(req),
    .irq_hi(irq_hi), .irq_od_dl(irq_od_dl)
  );

  assign dout_oe = |rd_en;
  assign dout    = dout_oe ? rdata[pick_ch] : '0;

  // R10: output enabled only for a strobe-style read strobe
  a_r10_oe_sep: assert property (@(posedge clk) disable iff (rst)
    (bus_sep && dout_oe) |-> (!rd_n && wr_n));
  // R10: output enabled only for a direction-style read
  a_r10_oe_dir: assert property (@(posedge clk) disable iff (rst)
    (!bus_sep && dout_oe) |-> (wr_n && !sel0_n));
  // R8: pin low forces divide-by-4 on every channel
  a_r8_pin_div4: assert property (@(posedge clk) disable iff (rst)
    !clk_sel |-> (div4_sel == '1));
endmodule

// File: tb/qbus_front_tb_top.sv
module qbus_front_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_pin, bus_sep, sel0_n, xa3, xa4, sel3_n, rd_n, wr_n, clk_sel;
  logic [2:0] addr;
  logic [7:0] din, dout;
  logic       dout_oe, irq_od_dl;
  logic [3:0] irq_hi, div4_sel;

  qbus_front dut_i (
    .clk(clk), .rst_pin(rst_pin), .bus_sep(bus_sep), .sel0_n(sel0_n),
    .xa3(xa3), .xa4(xa4), .sel3_n(sel3_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .clk_sel(clk_sel), .irq_hi(irq_hi), .irq_od_dl(irq_od_dl),
    .div4_sel(div4_sel)
  );

  int nvec = 0;
  int nbad = 0;
  logic [7:0] model [4][8];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 idle, 1 read, 2 write
  task automatic drive(input int ch, input logic [2:0] a, input int kind);
    addr = a;
    if (bus_sep) begin
      sel0_n = !(kind != 0 && ch == 0);
      xa3    = !(kind != 0 && ch == 1);
      xa4    = !(kind != 0 && ch == 2);
      sel3_n = !(kind != 0 && ch == 3);
      rd_n   = (kind != 1);
      wr_n   = (kind != 2);
    end else begin
      sel0_n = (kind == 0);
      xa3    = ch[0];
      xa4    = ch[1];
      sel3_n = 1'b0;             // ignored in this style
      wr_n   = (kind == 1);
      rd_n   = (kind == 1);      // misleading level, ignored
    end
  endtask

  task automatic do_write(input int ch, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    drive(ch, a, 2);
    din = d;
    @(posedge clk);
    model[ch][a] = d;
    @(negedge clk);
    drive(0, 0, 0);
  endtask

  task automatic do_read(input int ch, input logic [2:0] a, input string req);
    @(negedge clk);
    drive(ch, a, 1);
    #1;
    chk(req, {23'd0, dout_oe, dout}, {23'd0, 1'b1, model[ch][a]});
    @(negedge clk);
    drive(0, 0, 0);
  endtask

  function automatic logic [3:0] exp_req();
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = model[i][1][0];
    return r;
  endfunction

  function automatic logic [3:0] exp_div4();
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = !clk_sel || model[i][4][7];
    return r;
  endfunction

  task automatic clear_model();
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 8; a++) model[c][a] = 8'h00;
  endtask

  task automatic check_side();
    #1;
    if (bus_sep) begin
      chk("R6 irq_hi", {28'd0, irq_hi}, {28'd0, exp_req()});
      chk("R6 od idle", {31'd0, irq_od_dl}, 32'd0);
    end else begin
      chk("R7 irq_hi zero", {28'd0, irq_hi}, 32'd0);
      chk("R7 od pull", {31'd0, irq_od_dl}, {31'd0, |exp_req()});
    end
    chk("R8 div4", {28'd0, div4_sel}, {28'd0, exp_div4()});
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    bus_sep = 1'b1; rst_pin = 1'b1; clk_sel = 1'b1; din = '0;
    drive(0, 0, 0);
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_pin = 1'b0;
    // reset state (R5, R9)
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 8; a++) do_read(c, 3'(a), "R5 reset value");
    @(negedge clk);
    check_side();
    chk("R9 ovr clear", {28'd0, div4_sel}, 32'd0);

    // sweep both styles over every channel and register
    for (int m = 1; m >= 0; m--) begin
      @(negedge clk);
      bus_sep = m[0];
      rst_pin = m[0] ? 1'b0 : 1'b1;
      clk_sel = 1'b1;
      for (int c = 0; c < 4; c++)
        for (int a = 0; a < 8; a++)
          do_write(c, 3'(a), 8'((c * 37 + a * 11 + m * 90 + 5) & 255));
      for (int c = 0; c < 4; c++)
        for (int a = 0; a < 8; a++)
          do_read(c, 3'(a), m ? "R1 R2 strobe read" : "R3 dir read");
      @(negedge clk); check_side();
      clk_sel = 1'b0;
      @(negedge clk); check_side();
      clk_sel = 1'b1;
    end

    // R4 in strobe style: collisions and idle
    @(negedge clk);
    bus_sep = 1'b1; rst_pin = 1'b0;
    @(negedge clk);
    addr = 3'd2; din = 8'hA5; sel0_n = 0; xa3 = 0; xa4 = 1; sel3_n = 1; wr_n = 0; rd_n = 1;
    @(posedge clk); @(negedge clk);
    drive(0, 0, 0);
    do_read(0, 3'd2, "R4 collision ch0");
    do_read(1, 3'd2, "R4 collision ch1");
    @(negedge clk);
    addr = 3'd5; din = 8'h3C; sel3_n = 0; wr_n = 0; rd_n = 0;
    #1 chk("R4 both strobes oe", {31'd0, dout_oe}, 32'd0);
    @(posedge clk); @(negedge clk);
    drive(0, 0, 0);
    do_read(3, 3'd5, "R4 both strobes no write");
    @(negedge clk);
    addr = 3'd1; rd_n = 0;
    #1 chk("R4 no select oe", {31'd0, dout_oe}, 32'd0);
    chk("R10 dout zero", {24'd0, dout}, 32'd0);
    drive(0, 0, 0);

    // R4 in direction style: group select high
    @(negedge clk);
    bus_sep = 1'b0; rst_pin = 1'b1;
    @(negedge clk);
    addr = 3'd6; din = 8'h77; sel0_n = 1; xa3 = 1; xa4 = 0; wr_n = 0; rd_n = 0; sel3_n = 0;
    @(posedge clk); @(negedge clk);
    drive(0, 0, 0);
    do_read(1, 3'd6, "R4 dir deselected");

    // R5 polarity: high is not reset in direction style
    @(negedge clk); rst_pin = 1'b1;
    repeat (2) @(posedge clk);
    do_read(2, 3'd3, "R5 dir high holds");
    @(negedge clk); rst_pin = 1'b0;
    @(posedge clk); clear_model();
    @(negedge clk); rst_pin = 1'b1;
    do_read(2, 3'd3, "R5 dir low clears");
    do_read(0, 3'd7, "R5 dir low clears");

    // R7 targeted: one request pulls the shared line
    do_write(2, 3'd1, 8'h01);
    @(negedge clk); check_side();
    do_write(2, 3'd1, 8'h00);
    @(negedge clk); check_side();

    // R5 strobe style high resets; R8 override on one channel
    @(negedge clk); bus_sep = 1'b1; rst_pin = 1'b0;
    do_write(1, 3'd4, 8'h80);
    do_write(3, 3'd1, 8'h01);
    @(negedge clk); check_side();
    chk("R8 ovr ch1", {28'd0, div4_sel}, 32'h2);
    chk("R6 ch3 line", {28'd0, irq_hi}, 32'h8);
    @(negedge clk); rst_pin = 1'b1;
    @(posedge clk); clear_model();
    @(negedge clk); rst_pin = 1'b0;
    do_read(1, 3'd4, "R5 R9 strobe high clears");
    @(negedge clk); check_side();

    finish_up();
  end
endmodule